// File: doc/BRIEF.md
# Message Object Control and Status Register

This block is the control and status register of one message object inside a CAN controller. A host CPU sees it through an 8-bit register port. The CPU uses the block to arm the object with a ready bit and to choose which completion events interrupt it. The CAN protocol engine uses the block to learn whether it may service the object at all. The engine reports successful transmissions, successful receptions, incoming remote requests and the completion of those requests as single-cycle pulses.

A completed transfer raises a sticky interrupt-request flag, but only when the matching enable is set. The flag drives the `irq` output directly, and only the CPU can clear it. A remote-request pending flag follows the engine's request and completion pulses, and the CPU can clear it but never set it. A build-time parameter selects a receive-only object, in which the transmit-interrupt enable has no effect. The three lowest bits of the register show engine status and cannot be written.

Top module: `canobj_ctrl_reg`

## Requirements
- R1: After synchronous reset every stored bit is 0, so `host_rdata` reads 0 while `eng_status` is 0, and `irq`, `object_enabled` and `rmt_pending` are 0.
- R2: A host write (`host_sel` and `host_we` both 1) loads bit 7 (ready), bit 6 (transmit-interrupt enable) and bit 5 (receive-interrupt enable) from `host_wdata`. The new values are visible on `host_rdata` after the next clock edge.
- R3: `object_enabled` equals the ready bit (bit 7). A `soft_rst` pulse clears the ready bit, wins over a host write in the same cycle, and leaves every other bit unchanged.
- R4: A `tx_ok` pulse sets the interrupt-request flag (bit 4) only while the transmit-interrupt enable is 1.
- R5: An `rx_ok` pulse sets the interrupt-request flag only while the receive-interrupt enable is 1.
- R6: The interrupt-request flag is sticky. The hardware never clears it. A host write with bit 4 equal to 0 clears it, and a host write with bit 4 equal to 1 leaves it unchanged.
- R7: When a set event and a host clear of the interrupt-request flag fall in the same cycle, the flag ends up 1.
- R8: `irq` is 1 exactly when the interrupt-request flag is 1.
- R9: The remote-pending flag (bit 3, also on `rmt_pending`) is set by `rmt_req` and cleared by `rmt_done` or by a host write with bit 3 equal to 0. A host write can never set it. If `rmt_req` and a clear fall in the same cycle, the flag ends up 1.
- R10: Bits 2 to 0 of `host_rdata` show `eng_status`, and host writes to those bits have no effect.
- R11: With `RX_ONLY`=1, `tx_ok` never sets the interrupt-request flag, whatever the value of the transmit-interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Controller-wide soft reset pulse; clears the ready bit |
| host_sel | input | 1 | Host register select |
| host_we | input | 1 | Host write strobe, qualified by `host_sel` |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read view |
| tx_ok | input | 1 | Engine pulse: successful transmission |
| rx_ok | input | 1 | Engine pulse: successful reception and store |
| rmt_req | input | 1 | Engine pulse: remote request arrived for this object |
| rmt_done | input | 1 | Engine pulse: remote request serviced |
| eng_status | input | 3 | Engine status shown in bits 2 to 0 |
| object_enabled | output | 1 | Object may be serviced by the engine |
| rmt_pending | output | 1 | Remote request outstanding |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle and contend for one flag. The first is a completion event against a host clear of the interrupt-request flag. The second is a new remote request against a service completion or a host clear of the pending flag. The bench drives each pair in a single cycle and then reads the flag through `host_rdata` and the outputs, expecting it to be set. It also pairs a soft reset with a host write that tries to set the ready bit, and expects the ready bit to be 0.

// File: rtl/canobj_pkg.sv
package canobj_pkg;

    localparam int REG_W   = 8;
    localparam int STAT_W  = 3;
    localparam int BIT_RDY = 7;
    localparam int BIT_TIE = 6;
    localparam int BIT_RIE = 5;
    localparam int BIT_IRQ = 4;
    localparam int BIT_RMT = 3;

    typedef struct packed {
        logic rdy;
        logic tie;
        logic rie;
    } cfg_t;

    typedef struct packed {
        logic irq_flag;
        logic rmt_pend;
    } flag_t;

    typedef struct packed {
        logic tx_ok;
        logic rx_ok;
        logic rmt_req;
        logic rmt_done;
    } eng_ev_t;

    function automatic logic [REG_W-1:0] pack_view(cfg_t c, flag_t f,
                                                   logic [STAT_W-1:0] s);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_RDY]      = c.rdy;
        v[BIT_TIE]      = c.tie;
        v[BIT_RIE]      = c.rie;
        v[BIT_IRQ]      = f.irq_flag;
        v[BIT_RMT]      = f.rmt_pend;
        v[STAT_W-1:0]   = s;
        return v;
    endfunction

endpackage

// File: rtl/canobj_host_dec.sv
module canobj_host_dec
    import canobj_pkg::*;
(
    input  logic             host_sel,
    input  logic             host_we,
    input  logic [REG_W-1:0] host_wdata,
    output logic             load_cfg,
    output cfg_t             cfg_new,
    output logic             clr_irq,
    output logic             clr_rmt
);
    logic wr;
    logic unused_wr_low;

    assign wr            = host_sel & host_we;
    assign unused_wr_low = ^host_wdata[STAT_W-1:0];

    always_comb begin
        load_cfg    = wr;
        cfg_new.rdy = host_wdata[BIT_RDY];
        cfg_new.tie = host_wdata[BIT_TIE];
        cfg_new.rie = host_wdata[BIT_RIE];
        clr_irq     = wr & ~host_wdata[BIT_IRQ];
        clr_rmt     = wr & ~host_wdata[BIT_RMT];
    end
endmodule

// File: rtl/canobj_cfg_reg.sv
module canobj_cfg_reg
    import canobj_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic load_cfg,
    input  cfg_t cfg_new,
    output cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (load_cfg) begin
                cfg <= cfg_new;
            end
            if (soft_rst) begin
                cfg.rdy <= 1'b0;
            end
        end
    end

    // R3: soft reset leaves the object not ready
    a_r3_soft_clears_ready: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !cfg.rdy);

    // R3: soft reset alone keeps the enables
    a_r3_soft_keeps_enables: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !load_cfg) |=> $stable({cfg.tie, cfg.rie}));
endmodule

// File: rtl/canobj_flag_unit.sv
module canobj_flag_unit
    import canobj_pkg::*;
#(
    parameter bit RX_ONLY = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  cfg_t    cfg,
    input  eng_ev_t ev,
    input  logic    clr_irq,
    input  logic    clr_rmt,
    output flag_t   flags
);
    logic tx_arm;
    logic set_irq;
    logic unused_rdy;

    assign unused_rdy = cfg.rdy;

    generate
        if (RX_ONLY) begin : g_rx_only
            logic unused_tie;
            assign unused_tie = cfg.tie;
            assign tx_arm     = 1'b0;
        end else begin : g_full
            assign tx_arm = cfg.tie;
        end
    endgenerate

    assign set_irq = (ev.tx_ok & tx_arm) | (ev.rx_ok & cfg.rie);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (set_irq)
                flags.irq_flag <= 1'b1;
            else if (clr_irq)
                flags.irq_flag <= 1'b0;

            if (ev.rmt_req)
                flags.rmt_pend <= 1'b1;
            else if (clr_rmt || ev.rmt_done)
                flags.rmt_pend <= 1'b0;
        end
    end

    // R6: flag holds unless the host clears it
    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags.irq_flag && !clr_irq) |=> flags.irq_flag);

    // R7: an enabled event always leaves the flag set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ev.rx_ok && cfg.rie) |=> flags.irq_flag);

    // R5: no enabled event, no rise
    a_r5_no_spurious_rise: assert property (@(posedge clk) disable iff (rst)
        (!flags.irq_flag && !ev.tx_ok && !(ev.rx_ok && cfg.rie)) |=> !flags.irq_flag);

    // R9: a remote request always leaves the flag pending
    a_r9_req_sets: assert property (@(posedge clk) disable iff (rst)
        ev.rmt_req |=> flags.rmt_pend);

    // R9: only the engine request can raise the pending flag
    a_r9_no_host_set: assert property (@(posedge clk) disable iff (rst)
        (!flags.rmt_pend && !ev.rmt_req) |=> !flags.rmt_pend);

    generate
        if (RX_ONLY) begin : g_chk_rx
            // R11: transmit completion never raises the flag
            a_r11_tx_ignored: assert property (@(posedge clk) disable iff (rst)
                (!flags.irq_flag && !(ev.rx_ok && cfg.rie)) |=> !flags.irq_flag);
        end
    endgenerate
endmodule

// File: rtl/canobj_ctrl_reg.sv
module canobj_ctrl_reg
    import canobj_pkg::*;
#(
    parameter bit RX_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    input  logic              tx_ok,
    input  logic              rx_ok,
    input  logic              rmt_req,
    input  logic              rmt_done,
    input  logic [STAT_W-1:0] eng_status,
    output logic              object_enabled,
    output logic              rmt_pending,
    output logic              irq
);
    logic    load_cfg;
    cfg_t    cfg_new;
    cfg_t    cfg;
    logic    clr_irq;
    logic    clr_rmt;
    flag_t   flags;
    eng_ev_t ev;

    assign ev.tx_ok    = tx_ok;
    assign ev.rx_ok    = rx_ok;
    assign ev.rmt_req  = rmt_req;
    assign ev.rmt_done = rmt_done;

    canobj_host_dec u_dec (
        .host_sel   (host_sel),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .load_cfg   (load_cfg),
        .cfg_new    (cfg_new),
        .clr_irq    (clr_irq),
        .clr_rmt    (clr_rmt)
    );

    canobj_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .load_cfg (load_cfg),
        .cfg_new  (cfg_new),
        .cfg      (cfg)
    );

    canobj_flag_unit #(.RX_ONLY(RX_ONLY)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .ev      (ev),
        .clr_irq (clr_irq),
        .clr_rmt (clr_rmt),
        .flags   (flags)
    );

    assign host_rdata     = pack_view(cfg, flags, eng_status);
    assign object_enabled = cfg.rdy;
    assign rmt_pending    = flags.rmt_pend;
    assign irq            = flags.irq_flag;

    // R8: interrupt line only rises with a completion event
    a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tx_ok || rx_ok));
endmodule

// File: tb/canobj_ctrl_reg_test.sv
module canobj_ctrl_reg_test;
    logic       clk = 1'b0;
    logic       rst, soft_rst, host_sel, host_we;
    logic [7:0] host_wdata;
    logic       tx_ok, rx_ok, rmt_req, rmt_done;
    logic [2:0] eng_status;
    logic [7:0] rdata, rdata_rx;
    logic       en, en_rx, rp, rp_rx, irq, irq_rx;
    int         errors = 0;
    int         checks = 0;

    always #4 clk = ~clk;

    canobj_ctrl_reg #(.RX_ONLY(1'b0)) uut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .host_sel(host_sel),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(rdata),
        .tx_ok(tx_ok), .rx_ok(rx_ok), .rmt_req(rmt_req), .rmt_done(rmt_done),
        .eng_status(eng_status), .object_enabled(en), .rmt_pending(rp), .irq(irq));

    canobj_ctrl_reg #(.RX_ONLY(1'b1)) uut_rx (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .host_sel(host_sel),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(rdata_rx),
        .tx_ok(tx_ok), .rx_ok(rx_ok), .rmt_req(rmt_req), .rmt_done(rmt_done),
        .eng_status(eng_status), .object_enabled(en_rx), .rmt_pending(rp_rx), .irq(irq_rx));

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: inputs applied at a falling edge, outputs settle by the next one
    task automatic cyc(logic we, logic [7:0] wd, logic tx, logic rx,
                       logic rq, logic rd, logic sr);
        host_sel = we; host_we = we; host_wdata = wd;
        tx_ok = tx; rx_ok = rx; rmt_req = rq; rmt_done = rd; soft_rst = sr;
        @(negedge clk);
        host_sel = 0; host_we = 0; host_wdata = 8'h00;
        tx_ok = 0; rx_ok = 0; rmt_req = 0; rmt_done = 0; soft_rst = 0;
    endtask

    task automatic wr(logic [7:0] d); cyc(1, d, 0, 0, 0, 0, 0); endtask

    task automatic t_reset();
        rst = 1; cyc(0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 0); rst = 0;
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 outputs", {5'b0, en, rp, irq}, 8'h00);
    endtask

    task automatic t_cfg();
        wr(8'hF0);
        chk("R2 cfg bits", rdata & 8'hE0, 8'hE0);
        chk("R6 write1 no set", {7'b0, irq}, 8'h00);
        chk("R3 enabled", {7'b0, en}, 8'h01);
        wr(8'h20);
        chk("R2 reload", rdata & 8'hE0, 8'h20);
    endtask

    task automatic t_status();
        eng_status = 3'b101; #1;
        chk("R10 status view", rdata & 8'h07, 8'h05);
        wr(8'h82);
        chk("R10 write ignored", rdata & 8'h07, 8'h05);
        eng_status = 3'b000;
    endtask

    task automatic t_tx();
        wr(8'h80);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R4 tx disabled", {7'b0, irq}, 8'h00);
        wr(8'hC0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R4 tx enabled", rdata & 8'h10, 8'h10);
        chk("R8 irq", {7'b0, irq}, 8'h01);
        chk("R11 rx-only tx ignored", {7'b0, irq_rx}, 8'h00);
    endtask

    task automatic t_sticky();
        cyc(0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R6 holds", {7'b0, irq}, 8'h01);
        wr(8'hD0);
        chk("R6 write1 keeps", {7'b0, irq}, 8'h01);
        wr(8'hC0);
        chk("R6 write0 clears", {7'b0, irq}, 8'h00);
        chk("R8 irq low", rdata & 8'h10, 8'h00);
    endtask

    task automatic t_rx();
        wr(8'hA0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R5 rx enabled", {6'b0, irq, irq_rx}, 8'h03);
        wr(8'h80);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R5 rx disabled", {6'b0, irq, irq_rx}, 8'h00);
    endtask

    task automatic t_race();
        wr(8'hA0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(1, 8'hA0, 0, 1, 0, 0, 0);
        chk("R7 set beats clear", {7'b0, irq}, 8'h01);
        wr(8'hA0);
        chk("R7 later clear", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_rmt();
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R9 request sets", {6'b0, rp, rdata[3]}, 8'h03);
        wr(8'h88);
        chk("R9 write1 keeps", {7'b0, rp}, 8'h01);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R9 done clears", {7'b0, rp}, 8'h00);
        wr(8'h88);
        chk("R9 host cannot set", {7'b0, rp}, 8'h00);
        cyc(0, 0, 0, 0, 1, 0, 0);
        wr(8'h80);
        chk("R9 write0 clears", {7'b0, rp}, 8'h00);
        cyc(0, 0, 0, 0, 1, 1, 0);
        chk("R9 request beats done", {7'b0, rp}, 8'h01);
        cyc(1, 8'h80, 0, 0, 1, 0, 0);
        chk("R9 request beats host clear", {7'b0, rp}, 8'h01);
    endtask

    task automatic t_soft();
        wr(8'hE8);
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R3 soft clears ready", rdata & 8'hF8, 8'h78);
        chk("R3 enabled low", {7'b0, en}, 8'h00);
        cyc(1, 8'hF8, 0, 0, 0, 0, 1);
        chk("R3 soft beats write", rdata & 8'h80, 8'h00);
    endtask

    initial begin
        rst = 1; soft_rst = 0; host_sel = 0; host_we = 0; host_wdata = 0;
        tx_ok = 0; rx_ok = 0; rmt_req = 0; rmt_done = 0; eng_status = 0;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_status();
        t_tx();
        t_sticky();
        t_rx();
        t_race();
        t_rmt();
        t_soft();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule